// File: doc/BRIEF.md
# Reload Down-Counter with Snapshot Latching of Edge Counters and Captures

The block pairs a reloadable down-counter with four measurement channels. Each channel qualifies edges on one input pin, counts them in an 8-bit accumulator and stamps the timestamp bus into a capture register. Each accumulator and each capture register has a holding register beside it, so software can read a stable snapshot while live measurement goes on.

Two buffered schemes fill the holding registers. In snapshot mode the counter sets the sampling window. When it wraps through zero, when zero is written to it, or when a force strobe arrives, every live value is copied into its holding register in one cycle and the accumulators restart. In queue mode each channel shifts its previous capture into the holding register when a new edge is accepted, so the last two timestamps are always kept.

The counter has two states. IDLE is entered on reset or on a write of zero, and in it the count does not move. RUN is entered on a write of a non-zero value, and in it each tick decrements the count. The wrap step goes from RUN back to RUN and reloads the count. Each edge qualifier also has two states. WAIT watches for a selected edge and moves to HOLD when it sees one. HOLD returns to WAIT either by rejecting the edge, when the level drops back, or by accepting it, when the timer expires.

Top module: `snap_timer`

## Requirements
- R1: After reset the count is 0 with the counter in IDLE, `zero_pulse` is low, and every accumulator, capture, holding register and overflow bit reads 0.
- R2: Writing a non-zero N to the count enters RUN with both count and reload value set to N. Each cycle with `tick` high then decrements the count. The tick that finds the count at 1 reloads N instead and raises `zero_pulse` for one cycle, so the wraps come every N ticks.
- R3: Writing 0 to the count enters IDLE. The count then stays at 0 and no `zero_pulse` occurs whatever `tick` does. In snapshot mode with buffering on, that write is itself a snapshot event.
- R4: The two bits of `cfg_edge_sel` for channel i (bits 2i+1:2i) select the counted edge: bit 0 means rising, bit 1 means falling, 00 means none and 11 means both. Each accepted edge adds one to the channel's accumulator.
- R5: An edge is accepted only if the pin stays at its new level for at least QUAL_CYC+1 clock periods (3 with default parameters). Shorter pulses are rejected. While an edge is being qualified no other edge is looked at, so when a selected edge is rejected its return edge is not counted either.
- R6: An accumulator saturates at 0xFF. An accepted edge at 0xFF sets that channel's `acc_ovf` bit, and a snapshot event clears it.
- R7: With `cfg_buf_en`=1 and `cfg_latch_mode`=1, a counter wrap copies each accumulator and capture into its holding register in the same cycle and clears the accumulators.
- R8: `force_latch` causes a snapshot only when both `cfg_buf_en` and `cfg_latch_mode` are 1. In any other setting it leaves every output unchanged.
- R9: With `cfg_buf_en`=1 and `cfg_latch_mode`=0 (queue mode), each accepted edge moves the channel's previous capture into its capture holding register. Counter wraps neither clear nor copy the accumulators.
- R10: With `cfg_buf_en`=0 the holding registers never change.
- R11: If an edge is accepted in the same cycle as a snapshot event, the holding register receives the count from before that edge and the accumulator is left at 1.
- R12: An accepted edge loads the channel's capture register with `ts` as sampled in the cycle of acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled count enable for the down-counter |
| cnt_wr | input | 1 | Write strobe for the count register |
| cnt_wdata | input | 16 | Value to load as count and reload value |
| cfg_wr | input | 1 | Write strobe for the configuration fields |
| cfg_buf_en | input | 1 | Enables the holding registers |
| cfg_latch_mode | input | 1 | 1 = snapshot mode, 0 = queue mode |
| cfg_edge_sel | input | 8 | Two edge-select bits per channel |
| force_latch | input | 1 | Requests an immediate snapshot |
| pin_in | input | 4 | Measured input pins, one per channel |
| ts | input | 16 | Timestamp bus |
| cnt_val | output | 16 | Present count |
| zero_pulse | output | 1 | One-cycle pulse on each counter wrap |
| acc_live | output | 32 | Live accumulators, channel i in bits 8i+7:8i |
| acc_hold | output | 32 | Accumulator holding registers |
| acc_ovf | output | 4 | Saturation overflow bit per channel |
| cap_live | output | 64 | Live captures, channel i in bits 16i+15:16i |
| cap_hold | output | 64 | Capture holding registers |

## Verification
The bench sweeps pulse widths from one to five cycles across all four edge selections at once, so a design with an off-by-one qualification window, or one that counts the return edge of a rejected glitch, shows up as an accumulator that is one too high or too low. Counter periods of 1, 2, 5 and 9 are run at full and at half tick rate: a reload made one tick early or late changes the number of wraps counted. The accumulator is pushed through 255 and 256 edges to catch wrap-around or an early overflow bit. A force strobe is placed in exactly the cycle an edge is accepted, which catches a design that drops that edge or puts it into the snapshot.

// File: rtl/snap_pkg.sv
package snap_pkg;
    typedef enum logic [0:0] {C_IDLE = 1'b0, C_RUN = 1'b1} ctr_state_t;
    typedef enum logic [0:0] {Q_WAIT = 1'b0, Q_HOLD = 1'b1} qual_state_t;
endpackage

// File: rtl/snap_ctr.sv
module snap_ctr
    import snap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt_val,
    output logic             zero_evt,
    output logic             zero_wr,
    output logic             zero_pulse
);
    ctr_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, rld_q, rld_d;

    assign zero_wr = wr_en && (wr_data == '0);
    assign cnt_val = cnt_q;

    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        rld_d    = rld_q;
        zero_evt = 1'b0;
        if (wr_en) begin
            cnt_d = wr_data;
            rld_d = wr_data;
            st_d  = (wr_data == '0) ? C_IDLE : C_RUN;
        end else begin
            unique case (st_q)
                C_IDLE: st_d = C_IDLE;
                C_RUN: begin
                    if (tick) begin
                        if (cnt_q <= CNT_W'(1)) begin
                            cnt_d    = rld_q;
                            zero_evt = 1'b1;
                        end else begin
                            cnt_d = cnt_q - 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= C_IDLE;
            cnt_q      <= '0;
            rld_q      <= '0;
            zero_pulse <= 1'b0;
        end else begin
            st_q       <= st_d;
            cnt_q      <= cnt_d;
            rld_q      <= rld_d;
            zero_pulse <= zero_evt;
        end
    end

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == C_RUN && tick && !wr_en && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1) && !zero_pulse); // R2
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == C_RUN && tick && !wr_en && cnt_q == CNT_W'(1)) |=> zero_pulse && (cnt_q == rld_q)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == C_IDLE && !wr_en) |=> $stable(cnt_q) && !zero_pulse); // R3
endmodule

// File: rtl/snap_qual.sv
module snap_qual
    import snap_pkg::*;
#(
    parameter int QUAL_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] sel,
    output logic       hit
);
    localparam int TW = (QUAL_CYC > 1) ? $clog2(QUAL_CYC) : 1;

    qual_state_t   st_q, st_d;
    logic          s0_q, prev_q, lvl_q, lvl_d, hit_d;
    logic [TW-1:0] tmr_q, tmr_d;
    logic          rise_ok, fall_ok;

    assign rise_ok = s0_q && !prev_q && sel[0];
    assign fall_ok = !s0_q && prev_q && sel[1];

    always_comb begin
        st_d  = st_q;
        lvl_d = lvl_q;
        tmr_d = tmr_q;
        hit_d = 1'b0;
        unique case (st_q)
            Q_WAIT: begin
                if (rise_ok || fall_ok) begin
                    st_d  = Q_HOLD;
                    lvl_d = s0_q;
                    tmr_d = TW'(QUAL_CYC - 1);
                end
            end
            Q_HOLD: begin
                if (s0_q != lvl_q) begin
                    st_d = Q_WAIT;
                end else if (tmr_q == '0) begin
                    st_d  = Q_WAIT;
                    hit_d = 1'b1;
                end else begin
                    tmr_d = tmr_q - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= Q_WAIT;
            s0_q   <= 1'b0;
            prev_q <= 1'b0;
            lvl_q  <= 1'b0;
            tmr_q  <= '0;
            hit    <= 1'b0;
        end else begin
            st_q   <= st_d;
            s0_q   <= pin;
            prev_q <= s0_q;
            lvl_q  <= lvl_d;
            tmr_q  <= tmr_d;
            hit    <= hit_d;
        end
    end

    AST_ACCEPT_FROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(st_q) == Q_HOLD); // R5
    AST_GLITCH_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == Q_HOLD && s0_q != lvl_q) |=> (st_q == Q_WAIT) && !hit); // R5
endmodule

// File: rtl/snap_chan.sv
module snap_chan #(
    parameter int ACC_W = 8,
    parameter int TS_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [TS_W-1:0]  ts,
    input  logic             latch,
    input  logic             queue_shift,
    output logic [ACC_W-1:0] acc,
    output logic [ACC_W-1:0] acc_hold,
    output logic [TS_W-1:0]  cap,
    output logic [TS_W-1:0]  cap_hold,
    output logic             ovf
);
    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc      <= '0;
            acc_hold <= '0;
            cap      <= '0;
            cap_hold <= '0;
            ovf      <= 1'b0;
        end else begin
            if (latch) begin
                acc_hold <= acc;
                cap_hold <= cap;
                acc      <= hit ? ACC_W'(1) : '0;
                ovf      <= 1'b0;
            end else if (hit) begin
                if (acc == ACC_MAX) ovf <= 1'b1;
                else                acc <= acc + 1'b1;
                if (queue_shift)    cap_hold <= cap;
            end
            if (hit) cap <= ts;
        end
    end

    AST_ACC_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch && hit && acc == ACC_MAX) |=> (acc == ACC_MAX) && ovf); // R6
    AST_OVF_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> acc == ACC_MAX); // R6
    AST_LATCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        latch |=> (acc == ACC_W'($past(hit))) && !ovf); // R11
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch && !(queue_shift && hit)) |=> $stable(acc_hold) && $stable(cap_hold)); // R10
endmodule

// File: rtl/snap_timer.sv
module snap_timer
    import snap_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int CNT_W    = 16,
    parameter int ACC_W    = 8,
    parameter int TS_W     = 16,
    parameter int QUAL_CYC = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  cnt_wr,
    input  logic [CNT_W-1:0]      cnt_wdata,
    input  logic                  cfg_wr,
    input  logic                  cfg_buf_en,
    input  logic                  cfg_latch_mode,
    input  logic [2*NCH-1:0]      cfg_edge_sel,
    input  logic                  force_latch,
    input  logic [NCH-1:0]        pin_in,
    input  logic [TS_W-1:0]       ts,
    output logic [CNT_W-1:0]      cnt_val,
    output logic                  zero_pulse,
    output logic [NCH*ACC_W-1:0]  acc_live,
    output logic [NCH*ACC_W-1:0]  acc_hold,
    output logic [NCH-1:0]        acc_ovf,
    output logic [NCH*TS_W-1:0]   cap_live,
    output logic [NCH*TS_W-1:0]   cap_hold
);
    logic             buf_q, lmode_q;
    logic [2*NCH-1:0] sel_q;
    logic             zero_evt, zero_wr, latch, queue_shift;
    logic [NCH-1:0]   hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_q   <= 1'b0;
            lmode_q <= 1'b0;
            sel_q   <= '0;
        end else if (cfg_wr) begin
            buf_q   <= cfg_buf_en;
            lmode_q <= cfg_latch_mode;
            sel_q   <= cfg_edge_sel;
        end
    end

    snap_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(cnt_wr), .wr_data(cnt_wdata),
        .cnt_val(cnt_val), .zero_evt(zero_evt), .zero_wr(zero_wr), .zero_pulse(zero_pulse)
    );

    assign latch       = buf_q && lmode_q && (zero_evt || zero_wr || force_latch);
    assign queue_shift = buf_q && !lmode_q;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        snap_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
            .clk(clk), .rst_n(rst_n), .pin(pin_in[i]), .sel(sel_q[2*i +: 2]), .hit(hit[i])
        );
        snap_chan #(.ACC_W(ACC_W), .TS_W(TS_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .hit(hit[i]), .ts(ts), .latch(latch),
            .queue_shift(queue_shift),
            .acc(acc_live[i*ACC_W +: ACC_W]), .acc_hold(acc_hold[i*ACC_W +: ACC_W]),
            .cap(cap_live[i*TS_W +: TS_W]), .cap_hold(cap_hold[i*TS_W +: TS_W]),
            .ovf(acc_ovf[i])
        );
    end

    AST_FORCE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (force_latch && !(buf_q && lmode_q) && hit == '0) |=> $stable(acc_live) && $stable(acc_hold)); // R8
endmodule

// File: tb/sim_snap_timer.sv
`timescale 1ns/1ps
module sim_snap_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, cnt_wr = 1'b0, cfg_wr = 1'b0;
    logic [15:0] cnt_wdata = '0;
    logic        cfg_buf_en = 1'b0, cfg_latch_mode = 1'b0, force_latch = 1'b0;
    logic [7:0]  cfg_edge_sel = '0;
    logic [3:0]  pin_in = '0;
    logic [15:0] ts = '0;
    logic [15:0] cnt_val;
    logic        zero_pulse;
    logic [31:0] acc_live, acc_hold;
    logic [3:0]  acc_ovf;
    logic [63:0] cap_live, cap_hold;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    snap_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .cfg_wr(cfg_wr), .cfg_buf_en(cfg_buf_en), .cfg_latch_mode(cfg_latch_mode),
        .cfg_edge_sel(cfg_edge_sel), .force_latch(force_latch), .pin_in(pin_in), .ts(ts),
        .cnt_val(cnt_val), .zero_pulse(zero_pulse), .acc_live(acc_live), .acc_hold(acc_hold),
        .acc_ovf(acc_ovf), .cap_live(cap_live), .cap_hold(cap_hold)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(bit b, bit lm, logic [7:0] sel);
        cfg_buf_en = b; cfg_latch_mode = lm; cfg_edge_sel = sel; cfg_wr = 1'b1;
        step(1);
        cfg_wr = 1'b0;
    endtask

    task automatic wr_cnt(logic [15:0] v);
        cnt_wdata = v; cnt_wr = 1'b1;
        step(1);
        cnt_wr = 1'b0;
    endtask

    task automatic pulse(logic [3:0] m, int w);
        pin_in = m;
        step(w);
        pin_in = '0;
        step(8);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
    endtask

    function automatic int acc(int c);  return int'(acc_live[c*8 +: 8]);  endfunction
    function automatic int acch(int c); return int'(acc_hold[c*8 +: 8]);  endfunction
    function automatic int cap(int c);  return int'(cap_live[c*16 +: 16]); endfunction
    function automatic int caph(int c); return int'(cap_hold[c*16 +: 16]); endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int exp_acc[4];
        int exp_cap[4];
        int n;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        chk("R1 cnt_val", int'(cnt_val), 0);
        chk("R1 zero_pulse", int'(zero_pulse), 0);
        chk("R1 acc_live", int'(acc_live), 0);
        chk("R1 acc_hold", int'(acc_hold), 0);
        chk("R1 cap_live", int'(cap_live[31:0] | cap_live[63:32]), 0);
        chk("R1 acc_ovf", int'(acc_ovf), 0);

        // R4 R5 R12 edge sweep: ch0 none, ch1 rise, ch2 fall, ch3 both; unbuffered
        set_cfg(1'b0, 1'b0, 8'b11_10_01_00);
        for (int c = 0; c < 4; c++) begin exp_acc[c] = 0; exp_cap[c] = 0; end
        for (int w = 1; w <= 5; w++) begin
            ts = 16'h0100 + 16'(w);
            pulse(4'hF, w);
            for (int c = 0; c < 4; c++) begin
                bit r_ok, f_ok;
                r_ok = c[0] && (w >= 3);
                f_ok = c[1] && ((w >= 3) || !c[0]);
                exp_acc[c] += int'(r_ok) + int'(f_ok);
                if (r_ok || f_ok) exp_cap[c] = int'(ts);
                chk(w >= 3 ? "R4 acc edge count" : "R5 short pulse", acc(c), exp_acc[c]);
                chk("R12 capture ts", cap(c), exp_cap[c]);
            end
        end
        // R10 unbuffered: holds unchanged
        chk("R10 acc_hold", int'(acc_hold), 0);
        chk("R10 cap_hold", int'(cap_hold[31:0] | cap_hold[63:32]), 0);

        // R6 saturation
        do_reset();
        set_cfg(1'b0, 1'b0, 8'b11_10_01_00);
        for (int k = 0; k < 255; k++) pulse(4'b0010, 3);
        chk("R6 acc at 255", acc(1), 255);
        chk("R6 no ovf at 255", int'(acc_ovf[1]), 0);
        pulse(4'b0010, 3);
        chk("R6 acc holds 255", acc(1), 255);
        chk("R6 ovf set", int'(acc_ovf[1]), 1);
        chk("R4 none-select stays 0", acc(0), 0);

        // R8 force without snapshot mode has no effect
        set_cfg(1'b1, 1'b0, 8'b11_10_01_00);
        force_latch = 1'b1; step(1); force_latch = 1'b0; step(1);
        chk("R8 queue force acc_live", acc(1), 255);
        chk("R8 queue force acc_hold", acch(1), 0);
        chk("R8 queue force ovf", int'(acc_ovf[1]), 1);
        // R8 force in snapshot mode latches; R6 ovf cleared
        set_cfg(1'b1, 1'b1, 8'b11_10_01_00);
        force_latch = 1'b1; step(1); force_latch = 1'b0; step(1);
        chk("R8 force acc_hold", acch(1), 255);
        chk("R8 force acc_live cleared", acc(1), 0);
        chk("R6 ovf cleared by snapshot", int'(acc_ovf[1]), 0);

        // R7 snapshot on counter wrap
        tick = 1'b0;
        wr_cnt(16'd3);
        ts = 16'hABCD;
        pulse(4'b0010, 3);
        pulse(4'b0010, 3);
        tick = 1'b1; step(3); tick = 1'b0;
        chk("R2 zero_pulse on wrap", int'(zero_pulse), 1);
        chk("R2 reload after wrap", int'(cnt_val), 3);
        chk("R7 acc_hold", acch(1), 2);
        chk("R7 cap_hold", caph(1), 16'hABCD);
        chk("R7 acc cleared", acc(1), 0);
        step(1);
        chk("R2 zero_pulse one cycle", int'(zero_pulse), 0);

        // R2 period sweep, unbuffered
        set_cfg(1'b0, 1'b0, 8'b11_10_01_00);
        foreach (exp_acc[p]) begin
            int per;
            per = (p == 0) ? 1 : (p == 1) ? 2 : (p == 2) ? 5 : 9;
            tick = 1'b1;
            wr_cnt(16'(per));
            chk("R2 load value", int'(cnt_val), per);
            n = 0;
            for (int j = 1; j <= 3 * per; j++) begin
                step(1);
                if (zero_pulse) n++;
            end
            chk("R2 full rate wraps", n, 3);
            wr_cnt(16'(per));
            n = 0;
            for (int j = 1; j <= 8 * per; j++) begin
                tick = j[0];
                step(1);
                if (zero_pulse) n++;
            end
            chk("R2 half rate wraps", n, 4);
        end
        tick = 1'b0;

        // R3 zero write snapshots and stops the counter
        set_cfg(1'b1, 1'b1, 8'b11_10_01_00);
        force_latch = 1'b1; step(1); force_latch = 1'b0;
        wr_cnt(16'd5);
        ts = 16'h1234;
        pulse(4'b0010, 3); pulse(4'b0010, 3); pulse(4'b0010, 3);
        wr_cnt(16'd0);
        chk("R3 zero write acc_hold", acch(1), 3);
        chk("R3 zero write clears acc", acc(1), 0);
        chk("R3 count zero", int'(cnt_val), 0);
        tick = 1'b1;
        n = 0;
        for (int j = 0; j < 20; j++) begin step(1); if (zero_pulse) n++; end
        tick = 1'b0;
        chk("R3 no wrap when idle", n, 0);
        chk("R3 count stays zero", int'(cnt_val), 0);

        // R9 queue mode
        set_cfg(1'b1, 1'b0, 8'b11_10_01_00);
        ts = 16'h1111; pulse(4'b0010, 3);
        chk("R9 first hold", caph(1), 16'h1234);
        ts = 16'h2222; pulse(4'b0010, 3);
        chk("R9 cap_live", cap(1), 16'h2222);
        chk("R9 cap_hold", caph(1), 16'h1111);
        chk("R9 acc_hold untouched", acch(1), 3);
        tick = 1'b1;
        wr_cnt(16'd2);
        step(10);
        tick = 1'b0;
        chk("R9 wraps keep acc", acc(1), 2);

        // R11 edge accepted in the snapshot cycle
        set_cfg(1'b1, 1'b1, 8'b11_10_01_00);
        wr_cnt(16'd100);
        pin_in = 4'b0010;
        step(4);
        force_latch = 1'b1;
        step(1);
        force_latch = 1'b0;
        pin_in = '0;
        step(8);
        chk("R11 hold gets prior count", acch(1), 2);
        chk("R11 acc left at 1", acc(1), 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule